// File: doc/BRIEF.md
# Supply Alarm Status and Interrupt Register

This block collects level flags from external supply comparators into sticky status bits that software can read and clear over a simple register bus. A second register chooses which status bits may drive one level-sensitive interrupt line. There are four alarm flags: battery supply below its low threshold, digital regulator output below its low threshold, digital regulator output above its high threshold, and battery supply inside its upper range. A read-only mirror of the wake-controller enable acknowledge is also shown in the status word.

The comparator inputs arrive as levels that are already synchronized to `clk`. A status bit is set on the first clock edge at which its flag is high, and it stays set after the flag falls. Writing 1 to the bit clears it. If the flag is still high, the bit sets again, because a set always wins over a clear. The reset input is asserted asynchronously, and its release is synchronized inside the block.

Top module: `supply_alarm_regs`

## Requirements
- R1: During reset and after it is released, the status word reads 0x0000_0100 (only the upper-range bit is set), the enable word reads 0, and `alarm_irq` is low.
- R2: The status word is at offset 0x0. Bit 0 is the battery-low alarm, bit 1 is regulator-low, bit 2 is regulator-high and bit 8 is battery-upper-range. A flag that is high before a clock edge sets its bit at that edge. The bit stays set after the flag goes low.
- R3: Writing 1 to status bit 0, 1, 2 or 8 clears that bit at the write edge when its flag is low. Writing 0 to a bit leaves it unchanged.
- R4: When a flag is high in the same cycle as a clearing write to its bit, the bit remains 1.
- R5: Status bit 7 reads the current level of `wake_ack`. Status bits 6 to 3 and 31 to 9 always read 0, and writing to them has no effect.
- R6: The enable word is at offset 0x4. Bits 0, 1, 2 and 10 can be written and read back. Every other bit reads 0.
- R7: `alarm_irq` is high exactly when at least one of these pairs has both bits set: status bit 0 with enable bit 0, status bit 1 with enable bit 1, status bit 2 with enable bit 2, status bit 8 with enable bit 10. It follows the register contents with no added delay.
- R8: A write to any offset other than 0x0 or 0x4 changes no state. A read from such an offset returns 0, and `bus_rdata` is 0 whenever `bus_sel` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| mon_batt_low | input | 1 | Battery below its low threshold |
| mon_reg_low | input | 1 | Regulator output below its low threshold |
| mon_reg_high | input | 1 | Regulator output above its high threshold |
| mon_batt_upper | input | 1 | Battery inside its upper range |
| wake_ack | input | 1 | Wake-controller enable acknowledge |
| alarm_irq | output | 1 | Level interrupt |

## Verification
Flag and write effects become visible one clock edge after the stimulus: a flag or a write driven just after edge k shows up in `bus_rdata` and `alarm_irq` just after edge k+1. Reads and `wake_ack` are combinational, so they are valid in the same cycle. The bench drives every input 1 ns after a rising edge and samples a few nanoseconds later, before the next edge. It counts one edge for every status or enable update and no edge for reads. Reset release passes through a two-flop synchronizer, so the bench waits for that before its first check.

// File: rtl/supply_alarm_pkg.sv
package supply_alarm_pkg;
  localparam int unsigned N_ALARM  = 4;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 4;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_ENABLE = 4'h4;
  localparam int unsigned WAKE_POS = 7;
  // alarm order: battery low, regulator low, regulator high, battery upper range
  localparam int unsigned STAT_POS [N_ALARM] = '{0, 1, 2, 8};
  localparam int unsigned EN_POS   [N_ALARM] = '{0, 1, 2, 10};
  localparam logic        STAT_RST [N_ALARM] = '{1'b0, 1'b0, 1'b0, 1'b1};
endpackage

// File: rtl/supply_alarm_rst_sync.sv
module supply_alarm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_core_n = sync_q[1];
endmodule

// File: rtl/supply_alarm_sticky.sv
module supply_alarm_sticky #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic clr,
  output logic q
);
  logic q_d;
  logic upd;

  always_comb begin
    upd = cond | clr;
    q_d = cond | (q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= RST_VAL;
    else if (upd) q <= q_d;
  end

  // R2: a present flag is captured at the next edge
  a_r2_set_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cond |=> q);
  // R3: a clearing write with the flag low empties the bit
  a_r3_clear_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !cond) |=> !q);
  // R3: with no flag and no clear the bit holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !cond) |=> $stable(q));
  // R4: set beats clear
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && cond) |=> q);
endmodule

// File: rtl/supply_alarm_enable.sv
module supply_alarm_enable
  import supply_alarm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [DATA_W-1:0]  wdata,
  output logic [N_ALARM-1:0] en_q
);
  logic [N_ALARM-1:0] en_d;

  generate
    for (genvar g = 0; g < N_ALARM; g++) begin : g_en
      always_comb en_d[g] = wdata[EN_POS[g]];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en_q <= '0;
    else if (we) en_q <= en_d;
  end

  // R6: enable bits change only on a write to their register
  a_r6_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(en_q));
endmodule

// File: rtl/supply_alarm_regs.sv
module supply_alarm_regs
  import supply_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              mon_batt_low,
  input  logic              mon_reg_low,
  input  logic              mon_reg_high,
  input  logic              mon_batt_upper,
  input  logic              wake_ack,
  output logic              alarm_irq
);
  logic               rst_core_n;
  logic [N_ALARM-1:0] flag;
  logic [N_ALARM-1:0] st_q;
  logic [N_ALARM-1:0] st_clr;
  logic [N_ALARM-1:0] en_q;
  logic               wr_status;
  logic               wr_enable;
  logic [DATA_W-1:0]  status_word;
  logic [DATA_W-1:0]  enable_word;

  supply_alarm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  always_comb begin
    flag      = {mon_batt_upper, mon_reg_high, mon_reg_low, mon_batt_low};
    wr_status = bus_sel && bus_wr && (bus_addr == OFS_STATUS);
    wr_enable = bus_sel && bus_wr && (bus_addr == OFS_ENABLE);
  end

  generate
    for (genvar g = 0; g < N_ALARM; g++) begin : g_stat
      always_comb st_clr[g] = wr_status && bus_wdata[STAT_POS[g]];
      supply_alarm_sticky #(.RST_VAL(STAT_RST[g])) u_bit (
        .clk   (clk),
        .rst_n (rst_core_n),
        .cond  (flag[g]),
        .clr   (st_clr[g]),
        .q     (st_q[g])
      );
    end
  endgenerate

  supply_alarm_enable u_en (
    .clk   (clk),
    .rst_n (rst_core_n),
    .we    (wr_enable),
    .wdata (bus_wdata),
    .en_q  (en_q)
  );

  always_comb begin
    status_word           = '0;
    enable_word           = '0;
    status_word[WAKE_POS] = wake_ack;
    for (int i = 0; i < N_ALARM; i++) begin
      status_word[STAT_POS[i]] = st_q[i];
      enable_word[EN_POS[i]]   = en_q[i];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (bus_addr)
        OFS_STATUS: bus_rdata = status_word;
        OFS_ENABLE: bus_rdata = enable_word;
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign alarm_irq = |(st_q & en_q);

  // R7: with every enable clear the line stays low
  a_r7_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_core_n)
    (en_q == '0) |-> !alarm_irq);
  // R7: an enabled battery-low alarm drives the line
  a_r7_batt_low_drives: assert property (@(posedge clk) disable iff (!rst_core_n)
    (en_q[0] && $past(mon_batt_low)) |-> alarm_irq);
  // R5: status read shows the wake acknowledge and zero reserved bits
  a_r5_status_read: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_sel && !bus_wr && bus_addr == OFS_STATUS) |->
      (bus_rdata[WAKE_POS] == wake_ack && bus_rdata[6:3] == 4'h0));
  // R8: idle bus returns zero
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_core_n)
    !bus_sel |-> (bus_rdata == '0));
endmodule

// File: tb/test_supply_alarm_regs.sv
`timescale 1ns/1ps
module test_supply_alarm_regs;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        mon_batt_low, mon_reg_low, mon_reg_high, mon_batt_upper, wake_ack;
  logic        alarm_irq;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  supply_alarm_regs i_supply_alarm_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mon_batt_low(mon_batt_low), .mon_reg_low(mon_reg_low),
    .mon_reg_high(mon_reg_high), .mon_batt_upper(mon_batt_upper),
    .wake_ack(wake_ack), .alarm_irq(alarm_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic set_flags(input logic [3:0] p);
    {mon_batt_upper, mon_reg_high, mon_reg_low, mon_batt_low} = p;
  endtask

  function automatic logic [31:0] stat_of(input logic [3:0] p);
    return {23'd0, p[3], 5'd0, p[2:0]};
  endfunction

  function automatic logic [31:0] en_of(input logic [3:0] e);
    return {21'd0, e[3], 7'd0, e[2:0]};
  endfunction

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    set_flags(4'h0); wake_ack = 1'b0;
    repeat (3) tick();
    rd(4'h0, d); chk("R1 status in reset", d, 32'h100);
    rst_n = 1'b1;
    repeat (3) tick();
    rd(4'h0, d); chk("R1 status after reset", d, 32'h100);
    rd(4'h4, d); chk("R1 enable after reset", d, 32'h0);
    chk("R1 irq after reset", {31'd0, alarm_irq}, 32'h0);

    wr(4'h0, 32'h100);
    rd(4'h0, d); chk("R3 clear upper-range bit", d, 32'h0);

    for (int p = 0; p < 16; p++) begin
      set_flags(p[3:0]); tick(); set_flags(4'h0); tick();
      rd(4'h0, d); chk("R2 sticky capture", d, stat_of(p[3:0]));
      for (int e = 0; e < 16; e++) begin
        wr(4'h4, en_of(e[3:0]));
        rd(4'h4, d); chk("R6 enable readback", d, en_of(e[3:0]));
        chk("R7 irq level", {31'd0, alarm_irq},
            {31'd0, |(p[3:0] & e[3:0])});
      end
      wr(4'h4, 32'h0);
      wr(4'h0, 32'h0);
      rd(4'h0, d); chk("R3 write of zero keeps bits", d, stat_of(p[3:0]));
      wr(4'h0, 32'h107);
      rd(4'h0, d); chk("R3 write of ones clears", d, 32'h0);
    end

    // R3: single-bit clear leaves others
    set_flags(4'hF); tick(); set_flags(4'h0);
    wr(4'h0, 32'h002);
    rd(4'h0, d); chk("R3 clear one bit only", d, 32'h105);
    wr(4'h0, 32'h107);

    // R4: set beats clear
    mon_batt_low = 1'b1; tick();
    wr(4'h0, 32'h001);
    rd(4'h0, d); chk("R4 set wins over clear", d, 32'h001);
    mon_batt_low = 1'b0;
    wr(4'h0, 32'h001);
    rd(4'h0, d); chk("R4 clear after flag drops", d, 32'h0);

    // R5: wake mirror and reserved bits
    wake_ack = 1'b1;
    rd(4'h0, d); chk("R5 wake mirror high", d, 32'h080);
    wake_ack = 1'b0;
    rd(4'h0, d); chk("R5 wake mirror low", d, 32'h0);
    wr(4'h0, 32'hFFFF_FEF8);
    rd(4'h0, d); chk("R5 reserved writes ignored", d, 32'h0);
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, d); chk("R6 only defined enable bits", d, 32'h407);

    // R8: unmapped offsets
    set_flags(4'h5); tick(); set_flags(4'h0);
    wr(4'h8, 32'hFFFF_FFFF);
    wr(4'hC, 32'h0);
    rd(4'h0, d); chk("R8 status untouched", d, 32'h005);
    rd(4'h4, d); chk("R8 enable untouched", d, 32'h407);
    rd(4'h8, d); chk("R8 unmapped reads zero", d, 32'h0);
    chk("R8 idle bus zero", bus_rdata, 32'h0);
    chk("R7 irq from status bit 0", {31'd0, alarm_irq}, 32'h1);

    // R1: reset again mid-run
    rst_n = 1'b0; #1;
    rd(4'h0, d); chk("R1 reset restores status", d, 32'h100);
    chk("R1 reset drops irq", {31'd0, alarm_irq}, 32'h0);
    rst_n = 1'b1;
    repeat (3) tick();
    finish_run();
  end
endmodule